// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is a two-wire bus target that fronts a byte-wide register array. A fast system clock oversamples the serial clock and data lines. Each line passes through a two-stage synchronizer and a hold-off filter. Start, stop and clock edges are then derived from the filtered values. The block answers only when the first byte after a start matches the memory device type `1010b` and the three `dev_sel` inputs. It drives the data line only by pulling it low through `sda_oe`, and it never holds the clock low.

A write transaction loads a word address sent as two bytes, high byte first. Any number of data bytes may follow. Each data byte is stored the moment its eighth bit is sampled, so there is no busy time after a write. Reads and writes share one pointer, and the pointer keeps its value from one transaction to the next. A read-type device address therefore streams bytes from wherever the last access left the pointer. A random read is a write that carries only the address bytes, followed by a repeated start and a read-type device address.

While the `wp` input is high, the array and the pointer are both protected.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is asserted and immediately after it, `sda_oe` is 0, and the block ignores the bus until it sees a start.
- R2: The first byte after a start is acknowledged only when bits 7..4 equal 1010b and bits 3..1 equal `dev_sel`; bit 0 set to 1 means read and 0 means write. On a mismatch the block gives no acknowledge and keeps `sda_oe` at 0 until the next start or stop.
- R3: In a write, the two bytes after the device address are acknowledged and form the word address as {high[6:0], low}. Bit 7 of the high byte, and every bit at or above MEM_AW, are ignored.
- R4: With `wp` low, every data byte in a write is acknowledged and stored at the pointer, so a burst fills consecutive locations.
- R5: The pointer advances by one after each data byte, read or write, on the eighth clock, and wraps from 2^MEM_AW-1 to 0. Bursts have no length limit.
- R6: The pointer holds its value between transactions, and a read always starts at the current pointer.
- R7: A read shifts out the byte at the pointer, MSB first, from the falling SCL that ends the address acknowledge. It keeps sending bytes while the master acknowledges. A master no-acknowledge ends the read and leaves `sda_oe` at 0.
- R8: A start or stop that arrives before the eighth bit of a data byte leaves both the array and the pointer unchanged.
- R9: While `wp` is high, write data bytes get no acknowledge, nothing is stored and the pointer does not move. The device address and word-address bytes are still acknowledged.
- R10: A start at any point abandons the current operation and takes the next byte as a new device address, so a repeated start after the address bytes gives a random read.
- R11: `sda_oe` changes only while SCL is low, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| dev_sel | input | 3 | Device-select value compared with address bits 3..1 |
| wp | input | 1 | Write protect: 1 blocks data writes |

## Verification
The bench builds the block with MEM_AW=6, a 64-byte array, and the default synchronizer and filter depths. At that size a 70-byte burst crosses the top of the array and overwrites its own start. A four-byte random read from 3Eh also crosses the pointer wrap in a single transfer. The bench runs the serial clock at a quarter period of 12 system clocks. That leaves room for the filter delay, and the expected acknowledge and data samples fall in the middle of SCL high.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } phase_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // device-type and select match on a complete first byte
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
  endfunction

  // pointer step inside a 2^aw window, carried on 15 bits
  function automatic logic [14:0] ptr_step(input logic [14:0] p, input int aw);
    logic [14:0] m;
    m = 15'((32'd1 << aw) - 32'd1);
    return (p + 15'd1) & m;
  endfunction

endpackage

// File: rtl/i2c_pin_filter.sv
`timescale 1ns/1ps
module i2c_pin_filter #(
  parameter int LINES = 2,
  parameter int SYNC  = 2,
  parameter int HOLD  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] clean
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC-1:0] sync_q;
    logic [HOLD-1:0] hist_q;
    logic            out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        hist_q <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC-2:0], raw[g]};
        hist_q <= {hist_q[HOLD-2:0], sync_q[SYNC-1]};
        if (&hist_q)       out_q <= 1'b1;
        else if (~|hist_q) out_q <= 1'b0;
      end
    end

    assign clean[g] = out_q;
  end

endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_c,
  input  logic sda_c,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_c;
      sda_q <= sda_c;
    end
  end

  assign scl_rise  = scl_c & ~scl_q;
  assign scl_fall  = ~scl_c & scl_q;
  assign bus_start = scl_c & scl_q & sda_q & ~sda_c;
  assign bus_stop  = scl_c & scl_q & ~sda_q & sda_c;

endmodule

// File: rtl/i2c_byte_store.sv
`timescale 1ns/1ps
module i2c_byte_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic       wp
);

  localparam int WORD_W = 15;

  // filtered lines and bus events
  logic [1:0] clean;
  logic       scl_c, sda_c;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  i2c_pin_filter #(.LINES(2), .SYNC(SYNC_STAGES), .HOLD(FILT_LEN)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({sda_i, scl_i}),
    .clean (clean)
  );

  assign scl_c = clean[0];
  assign sda_c = clean[1];

  i2c_bus_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_c     (scl_c),
    .sda_c     (sda_c),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  // protocol state
  phase_t            st_q;
  logic [3:0]        cnt_q;
  logic [6:0]        sh_q;
  logic [6:0]        hi_q;
  logic              ack_go_q;
  logic              rd_q;
  logic              m_ack_q;
  logic [7:0]        tx_q;
  logic              oe_q;
  logic [MEM_AW-1:0] ptr_q;

  // named internal events
  logic [7:0]        rx_byte;
  logic              byte_end;
  logic              byte_ack;
  logic              mem_we;
  logic              ptr_inc;
  logic              ptr_load;
  logic              slot_go;
  logic [MEM_AW-1:0] ptr_nxt;
  logic [7:0]        mem_rdata;
  phase_t            phase_after;

  assign rx_byte  = {sh_q, sda_c};
  assign byte_end = scl_rise && (cnt_q == 4'd7) && (st_q != ST_IDLE);
  assign mem_we   = byte_end && (st_q == ST_WR) && !wp;
  assign ptr_load = byte_end && (st_q == ST_ALO);
  assign ptr_inc  = byte_end && (((st_q == ST_WR) && !wp) || (st_q == ST_RD));
  assign ptr_nxt  = MEM_AW'(ptr_step(WORD_W'(ptr_q), MEM_AW));
  assign slot_go  = (st_q == ST_RD) ? m_ack_q : ack_go_q;

  always_comb begin
    case (st_q)
      ST_DEV:          byte_ack = dev_hit(rx_byte, dev_sel);
      ST_AHI, ST_ALO:  byte_ack = 1'b1;
      ST_WR:           byte_ack = !wp;
      default:         byte_ack = 1'b0;
    endcase
  end

  always_comb begin
    case (st_q)
      ST_DEV:  phase_after = rd_q ? ST_RD : ST_AHI;
      ST_AHI:  phase_after = ST_ALO;
      ST_ALO:  phase_after = ST_WR;
      ST_WR:   phase_after = ST_WR;
      ST_RD:   phase_after = ST_RD;
      default: phase_after = ST_IDLE;
    endcase
  end

  i2c_byte_store #(.AW(MEM_AW), .DW(8)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr_q),
    .wdata (rx_byte),
    .raddr (ptr_q),
    .rdata (mem_rdata)
  );

  // pointer: loaded by the low address byte, stepped per data byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (ptr_load) ptr_q <= MEM_AW'({hi_q, rx_byte});
    else if (ptr_inc)  ptr_q <= ptr_nxt;
  end

  // bit sequencing: cnt_q counts SCL rises in the byte, 9 is the ack clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      hi_q     <= '0;
      ack_go_q <= 1'b0;
      rd_q     <= 1'b0;
      m_ack_q  <= 1'b0;
      tx_q     <= '0;
      oe_q     <= 1'b0;
    end else if (bus_start) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (bus_stop) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt_q != 4'd9) cnt_q <= cnt_q + 4'd1;
        if (cnt_q < 4'd8)  sh_q  <= rx_byte[6:0];
        if (byte_end) begin
          ack_go_q <= byte_ack;
          if (st_q == ST_DEV) rd_q <= rx_byte[0];
          if (st_q == ST_AHI) hi_q <= rx_byte[6:0];
        end
        if ((cnt_q == 4'd8) && (st_q == ST_RD)) m_ack_q <= ~sda_c;
      end else if (scl_fall) begin
        if (cnt_q == 4'd8) begin
          oe_q <= ack_go_q && (st_q != ST_RD);
        end else if (cnt_q == 4'd9) begin
          cnt_q <= '0;
          if (!slot_go) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
          end else begin
            st_q <= phase_after;
            if (phase_after == ST_RD) begin
              tx_q <= mem_rdata;
              oe_q <= ~mem_rdata[7];
            end else begin
              oe_q <= 1'b0;
            end
          end
        end else if ((st_q == ST_RD) && (cnt_q != 4'd0)) begin
          oe_q <= ~tx_q[~cnt_q[2:0]];
        end
      end
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/i2c_mem_target_chk.sv
`timescale 1ns/1ps
module i2c_mem_target_chk
  import i2c_mem_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_c,
  input logic          sda_oe,
  input phase_t        st_q,
  input logic [AW-1:0] ptr_q,
  input logic          wp,
  input logic          mem_we,
  input logic          ptr_load
);

  // R11: the output only moves while the filtered clock is low
  a_r11_hold_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_c && $past(scl_c)) |-> $stable(sda_oe));

  // R2/R7: an idle target leaves the line released
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe);

  // R9: protected write phase never moves the pointer
  a_r9_protect_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WR) && wp) |=> $stable(ptr_q));

  // R5: apart from an address load, the pointer only steps by one with wrap
  a_r5_ptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ptr_q) && !$past(ptr_load)) |-> (ptr_q == AW'(ptr_step(15'($past(ptr_q)), AW))));

  // R4: one array write per received byte
  a_r4_one_write_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(MEM_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_c    (scl_c),
  .sda_oe   (sda_oe),
  .st_q     (st_q),
  .ptr_q    (ptr_q),
  .wp       (wp),
  .mem_we   (mem_we),
  .ptr_load (ptr_load)
);

// File: tb/i2c_mem_target_bench.sv
`timescale 1ns/1ps
module i2c_mem_target_bench;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n   = 1'b0;
  logic       m_scl   = 1'b1;
  logic       m_sda   = 1'b1;
  logic       wp      = 1'b0;
  logic [2:0] dev_sel = 3'b101;
  logic       sda_oe;
  logic       sda_line;

  assign sda_line = m_sda & ~sda_oe;

  i2c_mem_target #(.MEM_AW(AW)) u_i2c_mem_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (m_scl),
    .sda_i   (sda_line),
    .sda_oe  (sda_oe),
    .dev_sel (dev_sel),
    .wp      (wp)
  );

  int   n_cmp = 0;
  int   n_bad = 0;
  int   ref_mem [DEPTH];
  int   ref_ptr = 0;
  logic watch_free = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison while the model says the target must stay silent
  always @(negedge clk) begin
    if (watch_free) begin
      n_cmp++;
      if (sda_oe) begin
        n_bad++;
        $display("FAIL R2 silent target drove line actual=1 expected=0");
      end
    end
  end

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_c(Q);
    m_scl = 1'b1; wait_c(2*Q);
    m_sda = 1'b0; wait_c(2*Q);
    m_scl = 1'b0; wait_c(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_c(Q);
    m_scl = 1'b1; wait_c(2*Q);
    m_sda = 1'b1; wait_c(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    wait_c(Q);
    m_scl = 1'b1; wait_c(2*Q);
    m_scl = 1'b0; wait_c(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; wait_c(Q);
    m_scl = 1'b1; wait_c(Q);
    acked = ~sda_line;
    wait_c(Q);
    m_scl = 1'b0; wait_c(Q);
  endtask

  task automatic get_bits(output logic [7:0] b);
    logic s0, s1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_c(Q);
      m_scl = 1'b1; wait_c(1);
      s0 = sda_line; wait_c(Q - 1);
      b[i] = sda_line; wait_c(Q - 1);
      s1 = sda_line; wait_c(1);
      m_scl = 1'b0;
      chk((s0 == b[i]) && (s1 == b[i]), "R11 data stable while SCL high", int'({s0, s1}), int'({b[i], b[i]}));
    end
    wait_c(Q);
  endtask

  task automatic ack_slot(input logic ack);
    m_sda = ~ack; wait_c(Q);
    m_scl = 1'b1; wait_c(2*Q);
    m_scl = 1'b0; wait_c(Q);
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] sel, input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo, input int n, input int seed);
    logic a;
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b0), a); chk(a, "R2 write device ack", a, 1);
    put_byte(hi, a); chk(a, "R3 high address ack", a, 1);
    put_byte(lo, a); chk(a, "R3 low address ack", a, 1);
    ref_ptr = int'({hi[6:0], lo}) % DEPTH;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'((k * 37 + seed) & 255);
      put_byte(d, a);
      if (wp) chk(!a, "R9 protected data nack", a, 0);
      else    chk(a, "R4 data ack", a, 1);
      if (!wp) begin
        ref_mem[ref_ptr] = int'(d);
        ref_ptr = (ref_ptr + 1) % DEPTH;
      end
    end
    bus_stop();
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      get_bits(b);
      chk(int'(b) == ref_mem[ref_ptr], req, int'(b), ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % DEPTH;
      ack_slot(k < n - 1);
    end
    wait_c(2);
    chk(!sda_oe, "R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic read_cur(input int n, input string req);
    logic a;
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b1), a); chk(a, "R2 read device ack", a, 1);
    read_body(n, req);
  endtask

  task automatic random_read(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    logic a;
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b0), a); chk(a, "R10 write device ack", a, 1);
    put_byte(hi, a); chk(a, "R3 high address ack", a, 1);
    put_byte(lo, a); chk(a, "R3 low address ack", a, 1);
    ref_ptr = int'({hi[6:0], lo}) % DEPTH;
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b1), a); chk(a, "R10 read device ack after repeated start", a, 1);
    read_body(n, req);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    wait_c(10);
    chk(!sda_oe, "R1 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    wait_c(20);
    chk(!sda_oe, "R1 released after reset", sda_oe, 0);

    // burst of 70 through the wrap; high byte junk above MEM_AW (R3, R5)
    write_seq(8'hC5, 8'h3C, 70, 11);
    // current-address read continues from the stored pointer (R6)
    read_cur(5, "R6 current read data");
    // random read crossing the top of the array (R5, R10)
    random_read(8'h00, 8'h3E, 4, "R5 wrap read data");

    // wrong select, then wrong type: silence and no change (R2)
    bus_start();
    watch_free = 1'b1;
    put_byte(dev_byte(3'b001, 1'b0), a); chk(!a, "R2 select mismatch nack", a, 0);
    put_byte(8'h00, a); chk(!a, "R2 no ack after mismatch", a, 0);
    put_byte(8'h10, a); chk(!a, "R2 no ack after mismatch", a, 0);
    put_byte(8'h55, a); chk(!a, "R2 no ack after mismatch", a, 0);
    bus_stop();
    bus_start();
    put_byte(8'hBA, a); chk(!a, "R2 type mismatch nack", a, 0);
    bus_stop();
    watch_free = 1'b0;
    read_cur(2, "R2 pointer and data untouched by mismatch");

    // byte cut by stop after five bits (R8)
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b0), a);
    put_byte(8'h00, a);
    put_byte(8'h05, a);
    put_byte(8'h11, a); chk(a, "R4 data ack", a, 1);
    ref_mem[5] = 'h11;
    ref_ptr = 6;
    for (int i = 7; i >= 3; i--) put_bit(b_pat(8'h99, i));
    bus_stop();
    read_cur(1, "R8 stop abort kept memory and pointer");

    // byte cut by repeated start, then read from the loaded address (R8, R10)
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b0), a);
    put_byte(8'h00, a);
    put_byte(8'h08, a);
    ref_ptr = 8;
    for (int i = 7; i >= 4; i--) put_bit(b_pat(8'h77, i));
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b1), a); chk(a, "R10 device ack after abort", a, 1);
    read_body(1, "R8 start abort kept memory");

    // write protect: addresses acked, data refused, pointer still (R9)
    wp = 1'b1;
    write_seq(8'h00, 8'h20, 1, 200);
    wp = 1'b0;
    ref_ptr = 'h20;
    read_cur(1, "R9 protected byte and pointer unchanged");

    // stop in the ninth clock ends a read (R7)
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b1), a);
    get_bits(b);
    chk(int'(b) == ref_mem[ref_ptr], "R7 read before stop", int'(b), ref_mem[ref_ptr]);
    ref_ptr = (ref_ptr + 1) % DEPTH;
    bus_stop();
    wait_c(4);
    chk(!sda_oe, "R7 released after stop in ack slot", sda_oe, 0);
    // start in the ninth clock, then read on (R7, R10)
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b1), a);
    get_bits(b);
    chk(int'(b) == ref_mem[ref_ptr], "R7 read before start", int'(b), ref_mem[ref_ptr]);
    ref_ptr = (ref_ptr + 1) % DEPTH;
    bus_start();
    put_byte(dev_byte(dev_sel, 1'b1), a); chk(a, "R10 device ack after start in ack slot", a, 1);
    read_body(3, "R7 sequential read data");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic b_pat(input logic [7:0] v, input int i);
    return v[i];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule